// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets an external controller read and write a parallel register space over a three-wire or four-wire link. The link has an active-low select, a serial clock, a shared data pin and an optional dedicated output pin. Each access begins with a 16-bit command word. The command word carries the access direction, a length code and a 13-bit starting register address. Data bytes follow the command. Bit order is chosen by a configuration input, and the register pointer moves automatically after every byte.

All link signals are resynchronised into the system clock domain, and edges are detected there. The register side of the block is a single-cycle strobe interface: a write strobe with address and data, and a read strobe whose returned data must be valid in the same cycle. A finite access may be paused by raising select on a byte boundary. A select rise in the middle of a byte discards the access. The same rule gives a controller a way to abandon a paused access: it drops select for one to seven clock periods and then raises it again.

Top module: `spi_reg_port`

## Requirements
- R1: The command word is 16 bits, captured on rising serial-clock edges while select is low. Bit 15 is 1 for a read and 0 for a write. Bits 14:13 are the length code. Bits 12:0 are the start address. In MSB-first mode bit 15 is sent first; in LSB-first mode bit 0 is sent first.
- R2: Length codes 0, 1 and 2 move exactly 1, 2 and 3 data bytes. Bytes clocked in after that, before select rises, cause no register access.
- R3: Length code 3 streams bytes with no limit until select rises.
- R4: After each data byte the register address steps by one, modulo 2^13, with no addresses skipped. It decrements in MSB-first mode (lsbFirst=0) and increments in LSB-first mode (lsbFirst=1).
- R5: Each completed write data byte gives exactly one single-cycle regWrEn pulse, carrying the assembled byte (in the configured bit order) and the current address.
- R6: Each read byte is fetched with a regRdEn pulse and shifted out in the configured bit order. The output bit changes only after falling serial-clock edges, so it is stable across each rising edge. The first bit is ready before the first rising edge of the data phase.
- R7: For finite accesses, select may rise on any byte boundary, in either the command or the data phase. Progress is kept, and the access resumes when select falls again.
- R8: A select rise while a byte is partly shifted discards that access. No write is issued, and the next select-low period starts a fresh command word.
- R9: A paused access is abandoned by holding select low for 1 to 7 serial-clock periods and then raising it. The next access then decodes its own command word.
- R10: sdioOe is 1 only during the data phase of a read, while select is low and unidir=0. It is 0 after reset.
- R11: With unidir=1, read data appears on sdoOut and sdioOe stays 0.
- R12: During reset and right after it, regWrEn, regRdEn and sdioOe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Active-low select from the link |
| sclk | input | 1 | Serial clock from the link |
| sdioIn | input | 1 | Input side of the shared data pin |
| lsbFirst | input | 1 | 1 = LSB-first bit order with incrementing address |
| unidir | input | 1 | 1 = read data on sdoOut (four-wire mode) |
| regRdData | input | 8 | Register read data, valid in the cycle regRdEn is high |
| sdioOut | output | 1 | Output side of the shared data pin |
| sdioOe | output | 1 | Output enable for the shared data pin |
| sdoOut | output | 1 | Dedicated read-data output |
| regAddr | output | 13 | Register address |
| regWrData | output | 8 | Register write data |
| regWrEn | output | 1 | Register write strobe |
| regRdEn | output | 1 | Register read strobe |

## Verification
A wrong bit or byte counter shows up at the register interface within one byte time. A write then lands at a shifted address, carries rotated data, or is missing or extra. A read returns a byte misaligned with its fetch. A pause or abandon that is handled wrongly leaves the block in the data phase, so the next command word is written into registers as data. This becomes visible in the very next access. An output-enable fault is caught by sampling sdioOe at every bit of the command and data phases.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phaseT;

  localparam logic [1:0] LEN_STREAM = 2'b11;

  typedef struct packed {
    logic clearAll;
    logic bitIn;
    logic shiftIns;
    logic latchInstr;
    logic shiftRx;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
  } spiStrobesT;

endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int INSTR_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       isRead,
  input  logic [1:0] lenCode,
  output spiStrobesT st,
  output logic       readPhase
);
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int INS_BYTES = INSTR_W / DATA_W;
  localparam int INS_CW    = (INS_BYTES > 1) ? $clog2(INS_BYTES) : 1;

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic csS, sclkS, sdiS, csPrev, sclkPrev;

  // Resynchronisers for the three link inputs.
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csPipe[g]   <= 1'b1;
          sclkPipe[g] <= 1'b0;
          sdiPipe[g]  <= 1'b0;
        end else if (g == 0) begin
          csPipe[g]   <= csN;
          sclkPipe[g] <= sclk;
          sdiPipe[g]  <= sdi;
        end else begin
          csPipe[g]   <= csPipe[(g == 0) ? 0 : g-1];
          sclkPipe[g] <= sclkPipe[(g == 0) ? 0 : g-1];
          sdiPipe[g]  <= sdiPipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign csS   = csPipe[SYNC_STAGES-1];
  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign sdiS  = sdiPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  phaseT             phase;
  logic [BIT_W-1:0]  bitCnt;
  logic [INS_CW-1:0] insByte;
  logic [1:0]        dataCnt;
  logic              loadPend, shiftPend;

  logic csLow, sclkRise, sclkFall, csRise;
  logic byteEnd, lastIns, lastData, idleNow, endOnRise;

  always_comb begin
    csLow     = ~csS;
    sclkRise  = csLow & sclkS & ~sclkPrev;
    sclkFall  = csLow & ~sclkS & sclkPrev;
    csRise    = csS & ~csPrev;
    byteEnd   = (bitCnt == BIT_W'(DATA_W-1));
    lastIns   = (insByte == INS_CW'(INS_BYTES-1));
    lastData  = (lenCode != LEN_STREAM) && (dataCnt == lenCode);
    idleNow   = (phase == PH_INSTR) && (insByte == '0) && (bitCnt == '0);
    // A select rise ends the access unless it is a byte-aligned pause of a finite one.
    endOnRise = (bitCnt != '0) || (phase == PH_DONE) || idleNow ||
                ((phase == PH_DATA) && (lenCode == LEN_STREAM));
  end

  always_comb begin
    st       = '0;
    st.bitIn = sdiS;
    if (csRise) begin
      st.clearAll = endOnRise;
    end else if (sclkRise) begin
      if (phase == PH_INSTR) begin
        st.shiftIns   = 1'b1;
        st.latchInstr = byteEnd & lastIns;
      end else if ((phase == PH_DATA) && !isRead) begin
        st.shiftRx   = 1'b1;
        st.writeByte = byteEnd;
      end
    end else if (sclkFall && (phase == PH_DATA) && isRead) begin
      st.loadTx  = loadPend;
      st.shiftTx = ~loadPend & shiftPend;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_INSTR;
      bitCnt    <= '0;
      insByte   <= '0;
      dataCnt   <= '0;
      loadPend  <= 1'b0;
      shiftPend <= 1'b0;
    end else if (st.clearAll) begin
      phase     <= PH_INSTR;
      bitCnt    <= '0;
      insByte   <= '0;
      dataCnt   <= '0;
      loadPend  <= 1'b0;
      shiftPend <= 1'b0;
    end else if (sclkRise) begin
      bitCnt <= byteEnd ? '0 : bitCnt + 1'b1;
      if (phase == PH_INSTR) begin
        if (byteEnd) begin
          if (lastIns) begin
            phase    <= PH_DATA;
            dataCnt  <= '0;
            loadPend <= 1'b1;
          end else begin
            insByte <= insByte + 1'b1;
          end
        end
      end else if (phase == PH_DATA) begin
        if (byteEnd) begin
          shiftPend <= 1'b0;
          if (lastData) begin
            phase <= PH_DONE;
          end else begin
            if (lenCode != LEN_STREAM) dataCnt <= dataCnt + 1'b1;
            loadPend <= isRead;
          end
        end else begin
          shiftPend <= isRead;
        end
      end
    end else if (sclkFall && (phase == PH_DATA) && isRead) begin
      if (loadPend) loadPend  <= 1'b0;
      else          shiftPend <= 1'b0;
    end
  end

  assign readPhase = csLow & (phase == PH_DATA) & isRead;

  // R8: a mid-byte select rise returns to a fresh command word.
  p_flush_mid_byte_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && (bitCnt != '0)) |=> (phase == PH_INSTR && bitCnt == '0 && insByte == '0));

  // R7: a byte-aligned rise during a finite data phase keeps the data phase.
  p_stall_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && (bitCnt == '0) && (phase == PH_DATA) && (lenCode != LEN_STREAM)) |=>
      (phase == PH_DATA));

  // R2: once the length is used up, no more register traffic.
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |-> !(st.writeByte || st.loadTx));

  // R2: the finite byte counter never passes its limit.
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && lenCode != LEN_STREAM) |-> (dataCnt <= lenCode));

endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 13,
  parameter int INSTR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobesT        st,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] regRdData,
  output logic              isRead,
  output logic [1:0]        lenCode,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              txBit
);
  logic [INSTR_W-1:0] insShift, insNext;
  logic [DATA_W-1:0]  rxShift, rxNext, txShift;
  logic [ADDR_W-1:0]  addrQ, addrStep;

  always_comb begin
    insNext  = lsbFirst ? {st.bitIn, insShift[INSTR_W-1:1]} : {insShift[INSTR_W-2:0], st.bitIn};
    rxNext   = lsbFirst ? {st.bitIn, rxShift[DATA_W-1:1]}   : {rxShift[DATA_W-2:0], st.bitIn};
    addrStep = lsbFirst ? addrQ + 1'b1 : addrQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insShift <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      addrQ    <= '0;
      isRead   <= 1'b0;
      lenCode  <= '0;
    end else if (st.clearAll) begin
      insShift <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      addrQ    <= '0;
      isRead   <= 1'b0;
      lenCode  <= '0;
    end else begin
      if (st.shiftIns) insShift <= insNext;
      if (st.shiftRx)  rxShift  <= rxNext;
      if (st.latchInstr) begin
        isRead  <= insNext[INSTR_W-1];
        lenCode <= insNext[INSTR_W-2 -: 2];
        addrQ   <= insNext[ADDR_W-1:0];
      end else if (st.writeByte || st.loadTx) begin
        addrQ <= addrStep;
      end
      if (st.loadTx) begin
        txShift <= regRdData;
      end else if (st.shiftTx) begin
        txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);
      end
    end
  end

  assign regAddr   = addrQ;
  assign regWrData = rxNext;
  assign regWrEn   = st.writeByte;
  assign regRdEn   = st.loadTx;
  assign txBit     = lsbFirst ? txShift[0] : txShift[DATA_W-1];

  // R5: write strobes only for a decoded write.
  p_write_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !isRead);

  // R6: read strobes only for a decoded read.
  p_read_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |-> isRead);

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdioIn,
  input  logic              lsbFirst,
  input  logic              unidir,
  input  logic [DATA_W-1:0] regRdData,
  output logic              sdioOut,
  output logic              sdioOe,
  output logic              sdoOut,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn
);
  localparam int INSTR_W = ADDR_W + 3;

  spiStrobesT st;
  logic       isRead, readPhase, txBit;
  logic [1:0] lenCode;

  spi_port_ctrl #(.DATA_W(DATA_W), .INSTR_W(INSTR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdioIn),
    .isRead(isRead), .lenCode(lenCode), .st(st), .readPhase(readPhase)
  );

  spi_port_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .lsbFirst(lsbFirst), .regRdData(regRdData),
    .isRead(isRead), .lenCode(lenCode), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .txBit(txBit)
  );

  assign sdioOut = txBit;
  assign sdioOe  = readPhase & ~unidir;
  assign sdoOut  = unidir ? txBit : 1'b0;

  // R10 / R11: the shared pin is never enabled in four-wire mode.
  p_oe_mode_r11: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> !unidir);

  // R5: a byte boundary never issues a read and a write together.
  p_single_access_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

endmodule

// File: tb/tb_spi_reg_port.sv
module tb_spi_reg_port;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdioIn = 1'b0;
  logic lsbFirst = 1'b0, unidir = 1'b0;
  logic [7:0]  regRdData, regWrData;
  logic [12:0] regAddr;
  logic sdioOut, sdioOe, sdoOut, regWrEn, regRdEn;

  always #2 clk = ~clk;

  spi_reg_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdioIn(sdioIn),
    .lsbFirst(lsbFirst), .unidir(unidir), .regRdData(regRdData),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdEn(regRdEn)
  );

  function automatic logic [7:0] rdModel(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [12:0] nextA(input logic [12:0] a, input logic lsb);
    return lsb ? a + 13'd1 : a - 13'd1;
  endfunction

  assign regRdData = rdModel(regAddr);

  int wrCount = 0, rdCount = 0;
  logic [12:0] logAddr [16];
  logic [7:0]  logData [16];
  always @(posedge clk) begin
    if (regWrEn) begin
      logAddr[wrCount % 16] <= regAddr;
      logData[wrCount % 16] <= regWrData;
      wrCount <= wrCount + 1;
    end
    if (regRdEn) rdCount <= rdCount + 1;
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spiBits(input logic [7:0] tx, input int n, input logic lsb,
                         output logic [7:0] rx, output logic oeAll,
                         output logic oeAny, output logic unstable);
    logic b;
    rx = '0; oeAll = 1'b1; oeAny = 1'b0; unstable = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdioIn = lsb ? tx[i] : tx[7-i];
      repeat (HALF) @(negedge clk);
      b = unidir ? sdoOut : sdioOut;
      oeAll = oeAll & sdioOe;
      oeAny = oeAny | sdioOe;
      if (lsb) rx[i] = b; else rx[7-i] = b;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if ((unidir ? sdoOut : sdioOut) !== b) unstable = 1'b1;
      sclk = 1'b0;
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, input logic lsb, output logic [7:0] rx,
                         output logic oeAll, output logic unstable);
    logic oeAny;
    spiBits(tx, 8, lsb, rx, oeAll, oeAny, unstable);
  endtask

  task automatic sendInstr(input logic rd, input logic [1:0] len, input logic [12:0] a,
                           input logic lsb, output logic oeAny);
    logic [15:0] ins;
    logic [7:0] rx;
    logic oa, o1, o2, un;
    ins = {rd, len, a};
    spiBits(lsb ? ins[7:0] : ins[15:8], 8, lsb, rx, oa, o1, un);
    spiBits(lsb ? ins[15:8] : ins[7:0], 8, lsb, rx, oa, o2, un);
    oeAny = o1 | o2;
  endtask

  task automatic csDown();
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csUp();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic expectWrite(input int idx, input logic [12:0] a, input logic [7:0] d, input string req);
    check(logAddr[idx % 16] == a, req, int'(logAddr[idx % 16]), int'(a));
    check(logData[idx % 16] == d, req, int'(logData[idx % 16]), int'(d));
  endtask

  typedef struct packed {
    logic        rd;
    logic        lsb;
    logic [1:0]  len;
    logic [12:0] addr;
    logic [31:0] data;
  } vecT;

  localparam vecT VECS [8] = '{
    '{1'b0, 1'b0, 2'd0, 13'h0010, 32'h0000005A},
    '{1'b0, 1'b1, 2'd1, 13'h0020, 32'h00002211},
    '{1'b0, 1'b0, 2'd2, 13'h0105, 32'h007E3CC3},
    '{1'b0, 1'b1, 2'd3, 13'h1FFE, 32'h04030201},
    '{1'b0, 1'b0, 2'd3, 13'h0001, 32'hD4C3B2A1},
    '{1'b1, 1'b0, 2'd0, 13'h0033, 32'h0},
    '{1'b1, 1'b1, 2'd2, 13'h1FFF, 32'h0},
    '{1'b1, 1'b0, 2'd3, 13'h00AB, 32'h0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic oeAll, oeAny, un;
    int wb;

    repeat (6) @(negedge clk);
    // R12: quiet during reset
    check(!regWrEn && !regRdEn, "R12 strobes in reset", int'({regWrEn, regRdEn}), 0);
    check(!sdioOe, "R12 oe in reset", int'(sdioOe), 0);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check(!regWrEn && !regRdEn && !sdioOe, "R12 after reset", int'({regWrEn, regRdEn, sdioOe}), 0);

    // Table walk: R1 R2 R3 R4 R5 R6 R10
    for (int v = 0; v < 8; v++) begin
      vecT cv;
      int nb, w0, r0;
      logic [12:0] a;
      logic insOe, dataOeAll, anyUnstable;
      logic [7:0] got [4];
      cv = VECS[v];
      nb = (cv.len == 2'd3) ? 4 : int'(cv.len) + 1;
      lsbFirst = cv.lsb;
      w0 = wrCount; r0 = rdCount;
      dataOeAll = 1'b1; anyUnstable = 1'b0;
      csDown();
      sendInstr(cv.rd, cv.len, cv.addr, cv.lsb, insOe);
      for (int b = 0; b < nb; b++) begin
        spiByte(cv.data[8*b +: 8], cv.lsb, got[b], oeAll, un);
        dataOeAll = dataOeAll & oeAll;
        anyUnstable = anyUnstable | un;
      end
      csUp();
      check(!sdioOe, "R10 oe off after access", int'(sdioOe), 0);
      check(!insOe, "R10 oe off in command phase", int'(insOe), 0);
      a = cv.addr;
      if (!cv.rd) begin
        check(wrCount - w0 == nb, "R2 R3 R5 write count", wrCount - w0, nb);
        for (int b = 0; b < nb; b++) begin
          expectWrite(w0 + b, a, cv.data[8*b +: 8], "R1 R4 R5 write addr/data");
          a = nextA(a, cv.lsb);
        end
      end else begin
        check(dataOeAll, "R10 oe on in read data", int'(dataOeAll), 1);
        check(!anyUnstable, "R6 output stable across rising edge", int'(anyUnstable), 0);
        if (cv.len != 2'd3)
          check(rdCount - r0 == nb, "R2 read fetch count", rdCount - r0, nb);
        for (int b = 0; b < nb; b++) begin
          check(got[b] == rdModel(a), "R1 R4 R6 read data", int'(got[b]), int'(rdModel(a)));
          a = nextA(a, cv.lsb);
        end
      end
    end

    // R2: bytes beyond the length are ignored
    lsbFirst = 1'b0;
    wb = wrCount;
    csDown();
    sendInstr(1'b0, 2'd0, 13'h0040, 1'b0, oeAny);
    spiByte(8'h99, 1'b0, rx, oeAll, un);
    spiByte(8'h77, 1'b0, rx, oeAll, un);
    csUp();
    check(wrCount - wb == 1, "R2 extra byte ignored", wrCount - wb, 1);
    expectWrite(wb, 13'h0040, 8'h99, "R2 first byte kept");

    // R7: pauses in command and data phases
    wb = wrCount;
    csDown(); spiBits(8'h20, 8, 1'b0, rx, oeAll, oeAny, un); csUp();
    csDown(); spiBits(8'h50, 8, 1'b0, rx, oeAll, oeAny, un); csUp();
    csDown(); spiByte(8'hA1, 1'b0, rx, oeAll, un); csUp();
    check(wrCount - wb == 1, "R7 first byte before pause", wrCount - wb, 1);
    csDown(); spiByte(8'hB2, 1'b0, rx, oeAll, un); csUp();
    check(wrCount - wb == 2, "R7 resumed write count", wrCount - wb, 2);
    expectWrite(wb, 13'h0050, 8'hA1, "R7 paused byte 0");
    expectWrite(wb + 1, 13'h004F, 8'hB2, "R7 paused byte 1");

    // R8: mid-byte select rise in data and command phases
    wb = wrCount;
    csDown();
    sendInstr(1'b0, 2'd0, 13'h0060, 1'b0, oeAny);
    spiBits(8'hFF, 5, 1'b0, rx, oeAll, oeAny, un);
    csUp();
    check(wrCount == wb, "R8 partial data byte discarded", wrCount - wb, 0);
    csDown(); spiBits(8'h00, 8, 1'b0, rx, oeAll, oeAny, un);
    spiBits(8'hFF, 3, 1'b0, rx, oeAll, oeAny, un); csUp();
    csDown();
    sendInstr(1'b0, 2'd0, 13'h0061, 1'b0, oeAny);
    spiByte(8'h3D, 1'b0, rx, oeAll, un);
    csUp();
    check(wrCount - wb == 1, "R8 fresh access after flush", wrCount - wb, 1);
    expectWrite(wb, 13'h0061, 8'h3D, "R8 fresh access data");

    // R9: abandon a paused access with a short select pulse
    wb = wrCount;
    csDown();
    sendInstr(1'b0, 2'd2, 13'h0070, 1'b0, oeAny);
    spiByte(8'h44, 1'b0, rx, oeAll, un);
    csUp();
    csDown(); spiBits(8'hFF, 3, 1'b0, rx, oeAll, oeAny, un); csUp();
    csDown();
    sendInstr(1'b0, 2'd0, 13'h0080, 1'b0, oeAny);
    spiByte(8'h55, 1'b0, rx, oeAll, un);
    csUp();
    check(wrCount - wb == 2, "R9 write count after abandon", wrCount - wb, 2);
    expectWrite(wb, 13'h0070, 8'h44, "R9 byte before abandon");
    expectWrite(wb + 1, 13'h0080, 8'h55, "R9 new command decoded");

    // R11: four-wire read
    unidir = 1'b1;
    begin
      logic [7:0] g0, g1;
      logic oeSeen;
      csDown();
      sendInstr(1'b1, 2'd1, 13'h0123, 1'b0, oeSeen);
      spiBits(8'h00, 8, 1'b0, g0, oeAll, oeAny, un);
      oeSeen = oeSeen | oeAny;
      spiBits(8'h00, 8, 1'b0, g1, oeAll, oeAny, un);
      oeSeen = oeSeen | oeAny;
      csUp();
      check(g0 == rdModel(13'h0123), "R11 sdo byte 0", int'(g0), int'(rdModel(13'h0123)));
      check(g1 == rdModel(13'h0122), "R11 sdo byte 1", int'(g1), int'(rdModel(13'h0122)));
      check(!oeSeen, "R11 oe stays low", int'(oeSeen), 0);
    end
    unidir = 1'b0;
    check(!sdioOe && !regWrEn && !regRdEn, "R10 idle at end", int'({sdioOe, regWrEn, regRdEn}), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule